// File: doc/BRIEF.md
# Packed Conversion Vector Lane Unit

This block is one lane of a SIMD vector ALU. An opcode selects one of four two-source operations. Three of them turn two 32-bit sources into two 16-bit results and pack those results into one 32-bit word:

- saturation to unsigned 16 bits,
- saturation to signed 16 bits,
- single-to-half float conversion that rounds toward zero.

The fourth operation is a per-lane select. It chooses one source or the other from one bit of a 64-bit lane mask, using the lane's own index to pick the bit.

Each source can carry an absolute-value modifier and a negate modifier. Both act on bit 31 of that source, before any operation runs. Absolute value clears the bit first, and negate then inverts it. If both are set, the source becomes its negated absolute value. This applies to the integer operations and to the select as well, not only to the float conversion.

The datapath is combinational and ends in one output register. The opcode decoder accepts the short two-operand codes and the long three-operand codes, which are the short code plus 0x100. The parent pipeline presents one operation per clock, qualified by `in_valid`. It reads `out_data` and `out_valid` one clock later.

Top module: `pcv_lane`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after reset, `out_valid` is 0 and `out_data` is 0.
- R2: Inputs sampled at a rising edge produce their result on `out_data`/`out_valid` right after that same edge, which is one clock of latency. A new operation is accepted every cycle.
- R3: Opcodes 0x030 and 0x130 perform the unsigned pack. Each modified source, taken as unsigned, is limited to at most 0xFFFF. The SRC0 result goes to bits 15:0 and the SRC1 result goes to bits 31:16.
- R4: Opcodes 0x031 and 0x131 perform the signed pack. Each modified source is read as signed 32-bit and saturated to the range -0x8000..0x7FFF. The SRC0 result goes to bits 15:0 and the SRC1 result goes to bits 31:16.
- R5: Opcodes 0x02F and 0x12F perform the half pack. Each modified source is read as an IEEE single and converted to IEEE half by truncating the mantissa bits that are dropped. The SRC0 half goes to bits 15:0 and the SRC1 half goes to bits 31:16.
- R6: The half conversion handles these special cases:
  - A finite input of magnitude 65536 or more becomes 0x7BFF, with the input's sign.
  - Infinity stays infinity (0x7C00, with sign).
  - Any NaN becomes 0x7E00, with sign.
  - A value below 2^-14 becomes a truncated half subnormal, or a signed zero.
- R7: Opcodes 0x000 and 0x100 perform the select. The output is modified SRC1 when `lane_mask[lane_id]` is 1, and modified SRC0 when it is 0.
- R8: For every operation, `abs` clears bit 31 of its source, and `neg` then inverts bit 31. Both are applied before the operation.
- R9: An opcode outside the eight listed above, or `in_valid` low, gives `out_data` = 0 and `out_valid` = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 9 | Operation code, short or long encoding |
| lane_id | input | 6 | Index of this lane within the wave |
| src0 | input | 32 | First source operand |
| src1 | input | 32 | Second source operand |
| lane_mask | input | 64 | Per-lane select mask |
| abs0 | input | 1 | Absolute-value modifier for src0 |
| neg0 | input | 1 | Negate modifier for src0 |
| abs1 | input | 1 | Absolute-value modifier for src1 |
| neg1 | input | 1 | Negate modifier for src1 |
| out_data | output | 32 | Packed or selected result |
| out_valid | output | 1 | Result valid and opcode supported |

## Verification
The only state in the block is the output register. A wrong opcode decode or a wrong modifier path therefore shows up on `out_data` or `out_valid` exactly one clock after the stimulus, and it never carries over into later cycles. Swapped halves, a clamp bound that is off by one, a wrong rounding direction, or a mask bit taken from the wrong index each give a word that differs from a hand-computed constant in the very next cycle. The stimulus therefore places values on both sides of every saturation bound and every float exponent boundary, and drives the same cases through both opcode encodings.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

    localparam int OPC_W = 9;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_SEL  = 3'd1,
        OP_HALF = 3'd2,
        OP_UPK  = 3'd3,
        OP_SPK  = 3'd4
    } pcv_op_e;

    localparam logic [5:0] BASE_SEL  = 6'h00;
    localparam logic [5:0] BASE_HALF = 6'h2F;
    localparam logic [5:0] BASE_UPK  = 6'h30;
    localparam logic [5:0] BASE_SPK  = 6'h31;

    function automatic pcv_op_e decode_op(input logic [OPC_W-1:0] opc);
        pcv_op_e   op;
        logic      enc_ok;
        enc_ok = (opc[8:6] == 3'b000) || (opc[8:6] == 3'b100);
        op     = OP_NONE;
        if (enc_ok) begin
            unique case (opc[5:0])
                BASE_SEL:  op = OP_SEL;
                BASE_HALF: op = OP_HALF;
                BASE_UPK:  op = OP_UPK;
                BASE_SPK:  op = OP_SPK;
                default:   op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/pcv_src_mod.sv
module pcv_src_mod #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_in,
    input  logic              abs_en,
    input  logic              neg_en,
    output logic [DATA_W-1:0] src_out
);
    localparam int SIGN_BIT = DATA_W - 1;

    logic sign_abs;

    always_comb begin
        sign_abs = abs_en ? 1'b0 : src_in[SIGN_BIT];
        src_out  = src_in;
        src_out[SIGN_BIT] = sign_abs ^ neg_en;
    end
endmodule

// File: rtl/pcv_sat16.sv
module pcv_sat16 #(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [DATA_W-1:0] val,
    input  logic              signed_mode,
    output logic [HALF_W-1:0] res
);
    localparam logic [DATA_W-1:0] U_MAX = DATA_W'((64'd1 << HALF_W) - 64'd1);
    localparam logic signed [DATA_W-1:0] S_MAX = DATA_W'((64'd1 << (HALF_W-1)) - 64'd1);
    localparam logic signed [DATA_W-1:0] S_MIN = -S_MAX - DATA_W'(1);

    logic signed [DATA_W-1:0] sval;

    always_comb begin
        sval = val;
        if (signed_mode) begin
            if (sval > S_MAX)      res = S_MAX[HALF_W-1:0];
            else if (sval < S_MIN) res = S_MIN[HALF_W-1:0];
            else                   res = sval[HALF_W-1:0];
        end else begin
            if (val > U_MAX) res = U_MAX[HALF_W-1:0];
            else             res = val[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/pcv_f2h_rtz.sv
module pcv_f2h_rtz (
    input  logic [31:0] f_in,
    output logic [15:0] h_out
);
    localparam logic [7:0]  E_MAX_H  = 8'd142;
    localparam logic [7:0]  E_MIN_N  = 8'd113;
    localparam logic [7:0]  E_BIAS_D = 8'd112;
    localparam logic [7:0]  SUB_REF  = 8'd126;
    localparam logic [14:0] H_MAXFIN = 15'h7BFF;
    localparam logic [14:0] H_INF    = 15'h7C00;
    localparam logic [14:0] H_QNAN   = 15'h7E00;

    logic        sgn;
    logic [7:0]  exp_f;
    logic [22:0] man_f;
    logic [7:0]  exp_h;
    logic [7:0]  sub_sh;
    logic [23:0] sub_man;

    always_comb begin
        sgn     = f_in[31];
        exp_f   = f_in[30:23];
        man_f   = f_in[22:0];
        exp_h   = exp_f - E_BIAS_D;
        sub_sh  = SUB_REF - exp_f;
        sub_man = {1'b1, man_f} >> sub_sh;
        if (exp_f == 8'hFF) begin
            h_out = {sgn, (man_f != 23'd0) ? H_QNAN : H_INF};
        end else if (exp_f > E_MAX_H) begin
            h_out = {sgn, H_MAXFIN};
        end else if (exp_f >= E_MIN_N) begin
            h_out = {sgn, exp_h[4:0], man_f[22:13]};
        end else if (exp_f == 8'd0) begin
            h_out = {sgn, 15'd0};
        end else begin
            h_out = {sgn, 5'd0, sub_man[9:0]};
        end
    end
endmodule

// File: rtl/pcv_lane.sv
module pcv_lane #(
    parameter int DATA_W = 32,
    parameter int MASK_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [8:0]                 opcode,
    input  logic [$clog2(MASK_W)-1:0]  lane_id,
    input  logic [DATA_W-1:0]          src0,
    input  logic [DATA_W-1:0]          src1,
    input  logic [MASK_W-1:0]          lane_mask,
    input  logic                       abs0,
    input  logic                       neg0,
    input  logic                       abs1,
    input  logic                       neg1,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_valid
);
    import pcv_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int NSRC   = 2;

    logic [DATA_W-1:0] raw   [NSRC];
    logic              abs_v [NSRC];
    logic              neg_v [NSRC];
    logic [DATA_W-1:0] msrc  [NSRC];
    logic [HALF_W-1:0] sat_r [NSRC];
    logic [HALF_W-1:0] hlf_r [NSRC];

    pcv_op_e           op_cur;
    logic              spk_mode;
    logic [DATA_W-1:0] res_nxt;
    logic              vld_nxt;

    always_comb begin
        raw[0]   = src0;  raw[1]   = src1;
        abs_v[0] = abs0;  abs_v[1] = abs1;
        neg_v[0] = neg0;  neg_v[1] = neg1;
    end

    always_comb begin
        op_cur   = decode_op(opcode);
        spk_mode = (op_cur == OP_SPK);
    end

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        pcv_src_mod #(.DATA_W(DATA_W)) u_mod (
            .src_in (raw[gi]),
            .abs_en (abs_v[gi]),
            .neg_en (neg_v[gi]),
            .src_out(msrc[gi])
        );
        pcv_sat16 #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_sat (
            .val        (msrc[gi]),
            .signed_mode(spk_mode),
            .res        (sat_r[gi])
        );
        pcv_f2h_rtz u_f2h (
            .f_in (msrc[gi]),
            .h_out(hlf_r[gi])
        );
    end

    always_comb begin
        res_nxt = '0;
        vld_nxt = 1'b0;
        if (in_valid) begin
            unique case (op_cur)
                OP_SEL: begin
                    res_nxt = lane_mask[lane_id] ? msrc[1] : msrc[0];
                    vld_nxt = 1'b1;
                end
                OP_HALF: begin
                    res_nxt = {hlf_r[1], hlf_r[0]};
                    vld_nxt = 1'b1;
                end
                OP_UPK, OP_SPK: begin
                    res_nxt = {sat_r[1], sat_r[0]};
                    vld_nxt = 1'b1;
                end
                default: begin
                    res_nxt = '0;
                    vld_nxt = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_data  <= res_nxt;
            out_valid <= vld_nxt;
        end
    end
endmodule

// File: rtl/pcv_lane_chk.sv
module pcv_lane_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [8:0]  opcode,
    input logic [5:0]  lane_id,
    input logic [31:0] src0,
    input logic [31:0] src1,
    input logic [63:0] lane_mask,
    input logic        abs0,
    input logic        neg0,
    input logic        abs1,
    input logic        neg1,
    input logic [31:0] out_data,
    input logic        out_valid
);
    logic op_known;
    logic no_mods;

    always_comb begin
        op_known = (opcode == 9'h000) || (opcode == 9'h100) ||
                   (opcode == 9'h02F) || (opcode == 9'h12F) ||
                   (opcode == 9'h030) || (opcode == 9'h130) ||
                   (opcode == 9'h031) || (opcode == 9'h131);
        no_mods  = !abs0 && !neg0 && !abs1 && !neg1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == 32'd0));

    // R9
    unknown_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !op_known) |=> (!out_valid && out_data == 32'd0));

    // R2
    known_op_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_known) |=> out_valid);

    // R7
    select_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[5:0] == 6'h00 && opcode[7:6] == 2'b00 && op_known && no_mods)
        |=> (out_data == ($past(lane_mask[lane_id]) ? $past(src1) : $past(src0))));

    // R3
    upack_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[5:0] == 6'h30 && op_known && !abs0 && !neg0 && src0 < 32'h10000)
        |=> (out_data[15:0] == $past(src0[15:0])));

    // R8
    select_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[5:0] == 6'h00 && op_known && !lane_mask[lane_id] && neg0 && !abs0)
        |=> (out_data == {~$past(src0[31]), $past(src0[30:0])}));
endmodule

bind pcv_lane pcv_lane_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .opcode   (opcode),
    .lane_id  (lane_id),
    .src0     (src0),
    .src1     (src1),
    .lane_mask(lane_mask),
    .abs0     (abs0),
    .neg0     (neg0),
    .abs1     (abs1),
    .neg1     (neg1),
    .out_data (out_data),
    .out_valid(out_valid)
);

// File: tb/pcv_lane_tb.sv
module pcv_lane_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  opcode = '0;
    logic [5:0]  lane_id = '0;
    logic [31:0] src0 = '0;
    logic [31:0] src1 = '0;
    logic [63:0] lane_mask = '0;
    logic        abs0 = 1'b0, neg0 = 1'b0, abs1 = 1'b0, neg1 = 1'b0;
    logic [31:0] out_data;
    logic        out_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        vld;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    pcv_lane u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .lane_id(lane_id), .src0(src0), .src1(src1), .lane_mask(lane_mask),
        .abs0(abs0), .neg0(neg0), .abs1(abs1), .neg1(neg1),
        .out_data(out_data), .out_valid(out_valid)
    );

    task automatic check(input string tag, input logic [31:0] ad, input logic av,
                         input logic [31:0] ed, input logic ev);
        n_chk++;
        if (ad !== ed || av !== ev) begin
            n_err++;
            $display("FAIL %s: actual data=%08h valid=%0b expected data=%08h valid=%0b",
                     tag, ad, av, ed, ev);
        end
    endtask

    task automatic drive(input string tag, input logic iv, input logic [8:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] mods, input logic [5:0] lane,
                         input logic [63:0] mask,
                         input logic [31:0] ed, input logic ev);
        exp_t e;
        @(negedge clk);
        in_valid = iv; opcode = op; src0 = a; src1 = b;
        {abs0, neg0, abs1, neg1} = mods;
        lane_id = lane; lane_mask = mask;
        e.data = ed; e.vld = ev; e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, out_data, out_valid, e.data, e.vld);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", out_data, out_valid, 32'd0, 1'b0);
        rst_n = 1'b1;

        drive("R3 upack 0x030", 1, 9'h030, 32'h0001_2345, 32'h0000_1234, 4'b0000, 0, 0, 32'h1234_FFFF, 1);
        drive("R3 upack 0x130", 1, 9'h130, 32'h0000_FFFF, 32'h0001_0000, 4'b0000, 0, 0, 32'hFFFF_FFFF, 1);
        drive("R3 upack pass", 1, 9'h130, 32'h0000_0000, 32'h0000_FFFE, 4'b0000, 0, 0, 32'hFFFE_0000, 1);
        drive("R4 spack 0x031", 1, 9'h031, 32'hFFFF_0000, 32'h0000_0005, 4'b0000, 0, 0, 32'h0005_8000, 1);
        drive("R4 spack bounds", 1, 9'h031, 32'h0000_7FFF, 32'h8000_0000, 4'b0000, 0, 0, 32'h8000_7FFF, 1);
        drive("R4 spack 0x131", 1, 9'h131, 32'h1234_5678, 32'hFFFF_FFFE, 4'b0000, 0, 0, 32'hFFFE_7FFF, 1);
        drive("R4 spack edge", 1, 9'h131, 32'h0000_8000, 32'hFFFF_8000, 4'b0000, 0, 0, 32'h8000_7FFF, 1);
        drive("R8 upack neg0 abs1", 1, 9'h030, 32'h0000_0010, 32'h8000_0020, 4'b0110, 0, 0, 32'h0020_FFFF, 1);
        drive("R8 spack abs+neg", 1, 9'h031, 32'h0000_0003, 32'h0000_0003, 4'b1100, 0, 0, 32'h0003_8000, 1);
        drive("R5 half 0x02F", 1, 9'h02F, 32'h3F80_0000, 32'hC000_0000, 4'b0000, 0, 0, 32'hC000_3C00, 1);
        drive("R5 half rtz 0x12F", 1, 9'h12F, 32'h3F80_1FFF, 32'h3FFF_FFFF, 4'b0000, 0, 0, 32'h3FFF_3C00, 1);
        drive("R6 overflow inf", 1, 9'h02F, 32'h4780_0000, 32'hFF80_0000, 4'b0000, 0, 0, 32'hFC00_7BFF, 1);
        drive("R6 max normal", 1, 9'h02F, 32'h477F_FFFF, 32'hC77F_E000, 4'b0000, 0, 0, 32'hFBFF_7BFF, 1);
        drive("R6 nan zero", 1, 9'h02F, 32'h7FC0_0000, 32'h0000_0000, 4'b0000, 0, 0, 32'h0000_7E00, 1);
        drive("R6 subnormal", 1, 9'h02F, 32'h3800_0000, 32'hB380_0000, 4'b0000, 0, 0, 32'h8001_0200, 1);
        drive("R6 tiny", 1, 9'h12F, 32'h0000_0001, 32'h3300_0000, 4'b0000, 0, 0, 32'h0000_0000, 1);
        drive("R6 min normal", 1, 9'h02F, 32'h3880_0000, 32'h387F_FFFF, 4'b0000, 0, 0, 32'h03FF_0400, 1);
        drive("R8 half neg0 abs1", 1, 9'h02F, 32'h3F80_0000, 32'hBF80_0000, 4'b0110, 0, 0, 32'h3C00_BC00, 1);
        drive("R7 sel lane63", 1, 9'h000, 32'hAAAA_0000, 32'h5555_0001, 4'b0000, 63, 64'h8000_0000_0000_0001, 32'h5555_0001, 1);
        drive("R7 sel lane1", 1, 9'h100, 32'hAAAA_0000, 32'h5555_0001, 4'b0000, 1, 64'h8000_0000_0000_0001, 32'hAAAA_0000, 1);
        drive("R7 sel lane0", 1, 9'h100, 32'hAAAA_0000, 32'h5555_0001, 4'b0000, 0, 64'h8000_0000_0000_0001, 32'h5555_0001, 1);
        drive("R8 sel neg1", 1, 9'h000, 32'h0000_0001, 32'h0000_0005, 4'b0001, 5, 64'h0000_0000_0000_0020, 32'h8000_0005, 1);
        drive("R8 sel abs0", 1, 9'h000, 32'hF000_0001, 32'h0000_0005, 4'b1000, 5, 64'h0, 32'h7000_0001, 1);
        drive("R9 bad op", 1, 9'h055, 32'h1234_5678, 32'h1234_5678, 4'b0000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 0);
        drive("R9 bad long op", 1, 9'h1B0, 32'h0001_2345, 32'h0, 4'b0000, 0, 0, 32'h0, 0);
        drive("R9 idle", 0, 9'h030, 32'h0001_2345, 32'h0, 4'b0000, 0, 0, 32'h0, 0);
        drive("R2 back-to-back", 1, 9'h031, 32'h0000_0001, 32'hFFFF_FFFF, 4'b0000, 0, 0, 32'hFFFF_0001, 1);
        drive("R9 idle end", 0, 9'h000, 32'h0, 32'h0, 4'b0000, 0, 0, 32'h0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule